// File: doc/BRIEF.md
# Receive TLP Routing Classifier

This block sits on the receive side of a PCI Express transaction layer in an endpoint. It reads the header dwords of each incoming TLP and chooses one of four destinations. These are the application receive interface, the internal configuration space, the internal message handler, or the discard path. It decides and flags only. It does not buffer payloads, build completions or send error messages.

The header arrives with a one-cycle strobe. The block decodes the format and type fields. It looks up memory and I/O addresses against the programmed base/mask windows, and it checks message codes. One registered cycle later it presents a one-hot route together with status flags. These flags mark a malformed header, an unsupported request, whether that request needs a completion, whether the TLP is dropped, and whether an error message to the root port is wanted.

Top module: `rx_tlp_router`

## Requirements
- R1: A memory or I/O request whose address falls in an enabled window is sent to the application (route bit 0). `bar_hit` is one-hot on the lowest-numbered matching window. A window hits when (address & mask) == base.
- R2: I/O requests (type 5'b00010) match only windows whose `bar_is_io` bit is set. Memory requests (type 5'b00000) match only windows whose `bar_is_io` bit is clear.
- R3: Setting `bar_is64` on an even window i joins windows i and i+1 into one 64-bit region: i holds the low half and i+1 the high half. Window i+1 then never hits on its own.
- R4: Vendor-defined messages (type 5'b10rrr, message code 0x7E or 0x7F in header dword 1 bits 7:0), with or without data, are sent to the application.
- R5: Type 0 configuration requests (type 5'b00100) are sent to the configuration space (route bit 1) and never to the application.
- R6: Messages with code 0x14, 0x18, 0x19, 0x1B (power management) or 0x50 (slot power limit) are consumed internally (route bit 2).
- R7: Every other TLP goes to the discard path (route bit 3) with `unsup_req` and `drop` set and `bar_hit` zero. This covers requests that hit no window, type 1 configuration, other message codes and other types.
- R8: `cpl_needed` is set only for unsupported non-posted requests: memory reads, I/O requests and configuration requests. It is clear for unsupported posted writes, messages and other types.
- R9: A memory request in the 4-DW format (format bit 0 = dword 0 bit 29) whose upper address dword is zero is flagged `malformed` and discarded. `unsup_req` and `cpl_needed` stay clear.
- R10: `err_msg_req` is set with `malformed` exactly when `aer_enable` was high as the header was taken.
- R11: Each `hdr_valid` cycle yields exactly one `route_valid` cycle, one clock later, with exactly one route bit set. Without `hdr_valid`, all outputs are zero. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header dwords valid this cycle |
| hdr_dw0 | input | 32 | Header dword 0: format [30:29], type [28:24] |
| hdr_dw1 | input | 32 | Header dword 1: message code [7:0] |
| hdr_dw2 | input | 32 | Header dword 2: address (3-DW) or upper address (4-DW) |
| hdr_dw3 | input | 32 | Header dword 3: lower address (4-DW) |
| bar_en | input | NUM_BAR | Window enable |
| bar_is_io | input | NUM_BAR | Window decodes I/O space |
| bar_is64 | input | NUM_BAR | Even window pairs with next as 64-bit region |
| bar_base | input | NUM_BAR*32 | Window base values |
| bar_mask | input | NUM_BAR*32 | Window address masks |
| aer_enable | input | 1 | Advanced error reporting on |
| route_valid | output | 1 | Decision valid |
| route_onehot | output | 4 | {discard, message, config, application} |
| bar_hit | output | NUM_BAR | Window hit by an application-routed request |
| malformed | output | 1 | Malformed header detected |
| unsup_req | output | 1 | Unsupported request |
| cpl_needed | output | 1 | Unsupported request needs a completion |
| drop | output | 1 | Header and data are dropped |
| err_msg_req | output | 1 | Request to send an error message |

## Verification
The in-line assertions watch the properties that must hold on every cycle. These are the one-cycle latency, a single route bit per result, and the consistency among the flags: malformed implies discard, a completion implies an unsupported request, an error request implies malformed with reporting enabled, and a window hit implies the application route. Only the bench scenarios can show that each header kind goes to the right destination. The same holds for window priority and enable, the 64-bit pair boundary, the I/O and memory window separation, and the posted versus non-posted completion rule.

// File: rtl/rx_route_pkg.sv
// Shared types and constants for the receive TLP routing classifier.
// Assumes PCI Express header field positions: format in dword 0 bits 30:29,
// type in bits 28:24, message code in dword 1 bits 7:0.
package rx_route_pkg;

    localparam int DW_W    = 32;
    localparam int ROUTE_W = 4;

    // Route bit positions inside route_onehot
    localparam int RT_APP  = 0;
    localparam int RT_CFG  = 1;
    localparam int RT_MSG  = 2;
    localparam int RT_DISC = 3;

    // Type field encodings
    localparam logic [4:0] TY_MEM  = 5'b00000;
    localparam logic [4:0] TY_IO   = 5'b00010;
    localparam logic [4:0] TY_CFG0 = 5'b00100;
    localparam logic [4:0] TY_CFG1 = 5'b00101;

    // Message codes of interest
    localparam logic [7:0] MC_VEND0     = 8'h7E;
    localparam logic [7:0] MC_VEND1     = 8'h7F;
    localparam logic [7:0] MC_ASPM_NAK  = 8'h14;
    localparam logic [7:0] MC_PME       = 8'h18;
    localparam logic [7:0] MC_PME_OFF   = 8'h19;
    localparam logic [7:0] MC_PME_ACK   = 8'h1B;
    localparam logic [7:0] MC_SLOT_PWR  = 8'h50;

    typedef enum logic [2:0] {
        K_MEM,
        K_IO,
        K_CFG0,
        K_CFG1,
        K_MSG,
        K_OTHER
    } tlp_kind_e;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               malformed;
        logic               unsup;
        logic               cpl_needed;
        logic               err_req;
    } verdict_t;

    // True for message codes the core absorbs itself
    function automatic logic is_internal_msg(input logic [7:0] code);
        return (code == MC_ASPM_NAK) || (code == MC_PME) ||
               (code == MC_PME_OFF)  || (code == MC_PME_ACK) ||
               (code == MC_SLOT_PWR);
    endfunction

    // True for vendor-defined message codes
    function automatic logic is_vendor_msg(input logic [7:0] code);
        return (code == MC_VEND0) || (code == MC_VEND1);
    endfunction

endpackage

// File: rtl/tlp_hdr_decode.sv
// Header field decoder.
// Splits the first header dwords into a TLP kind, format flags, the request
// address and the message code. Purely combinational. Assumes the caller
// only looks at the outputs while the header is valid.
module tlp_hdr_decode
    import rx_route_pkg::*;
(
    input  logic [DW_W-1:0]   dw0,
    input  logic [DW_W-1:0]   dw1,
    input  logic [DW_W-1:0]   dw2,
    input  logic [DW_W-1:0]   dw3,
    output tlp_kind_e         kind,
    output logic              is_4dw,
    output logic              has_data,
    output logic [2*DW_W-1:0] addr,
    output logic [7:0]        msg_code
);

    logic [4:0] typ;

    // Field extraction
    always_comb begin
        is_4dw   = dw0[29];
        has_data = dw0[30];
        typ      = dw0[28:24];
        msg_code = dw1[7:0];
    end

    // Kind classification from the type field
    always_comb begin
        if (typ == TY_MEM)             kind = K_MEM;
        else if (typ == TY_IO)         kind = K_IO;
        else if (typ == TY_CFG0)       kind = K_CFG0;
        else if (typ == TY_CFG1)       kind = K_CFG1;
        else if (typ[4:3] == 2'b10)    kind = K_MSG;
        else                           kind = K_OTHER;
    end

    // Address assembly: 4-DW puts the upper half in dword 2
    always_comb begin
        addr = is_4dw ? {dw2, dw3} : {{DW_W{1'b0}}, dw2};
    end

    logic unused_hdr_bits;
    assign unused_hdr_bits = ^{dw0[31], dw0[23:0], dw1[31:8]};

endmodule

// File: rtl/bar_hit_unit.sv
// Address window matcher.
// Compares a 64-bit request address against NUM_BAR base/mask windows.
// An even window with its 64-bit flag set forms one region with the next
// window as its upper half. A 32-bit window only hits addresses below 4 GB.
// The output is one-hot on the lowest matching window.
module bar_hit_unit
    import rx_route_pkg::*;
#(
    parameter int NUM_BAR = 6
) (
    input  logic [2*DW_W-1:0]             addr,
    input  logic                          want_io,
    input  logic [NUM_BAR-1:0]            bar_en,
    input  logic [NUM_BAR-1:0]            bar_is_io,
    input  logic [NUM_BAR-1:0]            bar_is64,
    input  logic [NUM_BAR-1:0][DW_W-1:0]  bar_base,
    input  logic [NUM_BAR-1:0][DW_W-1:0]  bar_mask,
    output logic [NUM_BAR-1:0]            hit,
    output logic                          any_hit
);

    logic [NUM_BAR-1:0] raw;

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
        logic lo_ok;
        logic hi_ok;
        logic upper_half;

        // Low dword compare for this window
        assign lo_ok = (addr[DW_W-1:0] & bar_mask[i]) == bar_base[i];

        if ((i % 2 == 0) && (i + 1 < NUM_BAR)) begin : g_pairable
            // Upper dword compare: paired window or must be zero
            assign hi_ok = bar_is64[i]
                ? ((addr[2*DW_W-1:DW_W] & bar_mask[i+1]) == bar_base[i+1])
                : (addr[2*DW_W-1:DW_W] == '0);
        end else begin : g_single
            assign hi_ok = (addr[2*DW_W-1:DW_W] == '0);
        end

        if (i % 2 == 1) begin : g_upper
            // Suppressed when consumed as the upper half of a pair
            assign upper_half = bar_is64[i-1];
        end else begin : g_lower
            assign upper_half = 1'b0;
        end

        assign raw[i] = bar_en[i] & ~upper_half &
                        (bar_is_io[i] == want_io) & lo_ok & hi_ok;
    end

    // Lowest-index priority pick
    always_comb begin
        hit     = raw & (~raw + NUM_BAR'(1));
        any_hit = |raw;
    end

    logic unused_is64;
    assign unused_is64 = ^bar_is64;

endmodule

// File: rtl/route_resolve.sv
// Routing decision logic.
// Combines the decoded kind, format, address and window hit into a single
// verdict: route, malformed, unsupported, completion-needed and error
// request. Combinational; the caller registers the result.
module route_resolve
    import rx_route_pkg::*;
#(
    parameter int NUM_BAR = 6
) (
    input  tlp_kind_e            kind,
    input  logic                 is_4dw,
    input  logic                 has_data,
    input  logic                 addr_hi_zero,
    input  logic [7:0]           msg_code,
    input  logic [NUM_BAR-1:0]   hit,
    input  logic                 any_hit,
    input  logic                 aer_en,
    output verdict_t             verdict,
    output logic [NUM_BAR-1:0]   hit_out
);

    localparam logic [ROUTE_W-1:0] ONE = ROUTE_W'(1);

    // Destination selection per kind
    always_comb begin
        verdict = '0;
        hit_out = '0;
        unique case (kind)
            K_MEM: begin
                if (is_4dw && addr_hi_zero) begin
                    verdict.route     = ONE << RT_DISC;
                    verdict.malformed = 1'b1;
                end else if (any_hit) begin
                    verdict.route = ONE << RT_APP;
                    hit_out       = hit;
                end else begin
                    verdict.route      = ONE << RT_DISC;
                    verdict.unsup      = 1'b1;
                    verdict.cpl_needed = ~has_data;
                end
            end
            K_IO: begin
                if (any_hit) begin
                    verdict.route = ONE << RT_APP;
                    hit_out       = hit;
                end else begin
                    verdict.route      = ONE << RT_DISC;
                    verdict.unsup      = 1'b1;
                    verdict.cpl_needed = 1'b1;
                end
            end
            K_CFG0: begin
                verdict.route = ONE << RT_CFG;
            end
            K_CFG1: begin
                verdict.route      = ONE << RT_DISC;
                verdict.unsup      = 1'b1;
                verdict.cpl_needed = 1'b1;
            end
            K_MSG: begin
                if (is_vendor_msg(msg_code)) begin
                    verdict.route = ONE << RT_APP;
                end else if (is_internal_msg(msg_code)) begin
                    verdict.route = ONE << RT_MSG;
                end else begin
                    verdict.route = ONE << RT_DISC;
                    verdict.unsup = 1'b1;
                end
            end
            default: begin
                verdict.route = ONE << RT_DISC;
                verdict.unsup = 1'b1;
            end
        endcase
        verdict.err_req = verdict.malformed & aer_en;
    end

endmodule

// File: rtl/rx_tlp_router.sv
// Receive TLP routing classifier, endpoint mode.
// Takes one header per hdr_valid cycle and presents a registered routing
// verdict exactly one cycle later for one cycle. Assumes the window
// registers are stable while headers are presented.
module rx_tlp_router
    import rx_route_pkg::*;
#(
    parameter int NUM_BAR = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hdr_valid,
    input  logic [31:0]                   hdr_dw0,
    input  logic [31:0]                   hdr_dw1,
    input  logic [31:0]                   hdr_dw2,
    input  logic [31:0]                   hdr_dw3,
    input  logic [NUM_BAR-1:0]            bar_en,
    input  logic [NUM_BAR-1:0]            bar_is_io,
    input  logic [NUM_BAR-1:0]            bar_is64,
    input  logic [NUM_BAR-1:0][31:0]      bar_base,
    input  logic [NUM_BAR-1:0][31:0]      bar_mask,
    input  logic                          aer_enable,
    output logic                          route_valid,
    output logic [3:0]                    route_onehot,
    output logic [NUM_BAR-1:0]            bar_hit,
    output logic                          malformed,
    output logic                          unsup_req,
    output logic                          cpl_needed,
    output logic                          drop,
    output logic                          err_msg_req
);

    tlp_kind_e            kind;
    logic                 is_4dw;
    logic                 has_data;
    logic [2*DW_W-1:0]    addr;
    logic [7:0]           msg_code;
    logic [NUM_BAR-1:0]   hit;
    logic                 any_hit;
    logic [NUM_BAR-1:0]   hit_sel;
    verdict_t             verdict_d;
    verdict_t             verdict_q;
    logic [NUM_BAR-1:0]   hit_q;
    logic                 valid_q;

    tlp_hdr_decode u_decode (
        .dw0      (hdr_dw0),
        .dw1      (hdr_dw1),
        .dw2      (hdr_dw2),
        .dw3      (hdr_dw3),
        .kind     (kind),
        .is_4dw   (is_4dw),
        .has_data (has_data),
        .addr     (addr),
        .msg_code (msg_code)
    );

    bar_hit_unit #(.NUM_BAR(NUM_BAR)) u_bars (
        .addr      (addr),
        .want_io   (kind == K_IO),
        .bar_en    (bar_en),
        .bar_is_io (bar_is_io),
        .bar_is64  (bar_is64),
        .bar_base  (bar_base),
        .bar_mask  (bar_mask),
        .hit       (hit),
        .any_hit   (any_hit)
    );

    route_resolve #(.NUM_BAR(NUM_BAR)) u_resolve (
        .kind         (kind),
        .is_4dw       (is_4dw),
        .has_data     (has_data),
        .addr_hi_zero (addr[2*DW_W-1:DW_W] == '0),
        .msg_code     (msg_code),
        .hit          (hit),
        .any_hit      (any_hit),
        .aer_en       (aer_enable),
        .verdict      (verdict_d),
        .hit_out      (hit_sel)
    );

    // Output register: one-cycle decision latency, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
            hit_q     <= '0;
        end else begin
            valid_q   <= hdr_valid;
            verdict_q <= hdr_valid ? verdict_d : '0;
            hit_q     <= hdr_valid ? hit_sel   : '0;
        end
    end

    // Port mapping of the registered verdict
    always_comb begin
        route_valid  = valid_q;
        route_onehot = verdict_q.route;
        bar_hit      = hit_q;
        malformed    = verdict_q.malformed;
        unsup_req    = verdict_q.unsup;
        cpl_needed   = verdict_q.cpl_needed;
        drop         = verdict_q.route[RT_DISC];
        err_msg_req  = verdict_q.err_req;
    end

    // R11
    route_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $countones(route_onehot) == 1);

    // R11
    route_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> route_valid);

    // R11
    route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!route_valid && route_onehot == '0 && !err_msg_req));

    // R9
    malformed_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        malformed |-> (drop && !unsup_req && !cpl_needed && bar_hit == '0));

    // R7
    unsup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_req |-> (drop && !malformed && bar_hit == '0));

    // R8
    cpl_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_needed |-> unsup_req);

    // R10
    err_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_msg_req |-> (malformed && $past(aer_enable)));

    // R1
    hit_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_hit != '0) |-> (route_onehot[RT_APP] && $onehot(bar_hit)));

endmodule

// File: tb/rx_tlp_router_bench.sv
module rx_tlp_router_bench;

    localparam int NB = 6;

    localparam logic [3:0] APP  = 4'b0001;
    localparam logic [3:0] CFG  = 4'b0010;
    localparam logic [3:0] MSG  = 4'b0100;
    localparam logic [3:0] DISC = 4'b1000;

    localparam logic [31:0] MRD3 = 32'h0000_0001;
    localparam logic [31:0] MWR3 = 32'h4000_0001;
    localparam logic [31:0] MRD4 = 32'h2000_0001;
    localparam logic [31:0] MWR4 = 32'h6000_0001;
    localparam logic [31:0] IORD = 32'h0200_0001;
    localparam logic [31:0] IOWR = 32'h4200_0001;
    localparam logic [31:0] CF0R = 32'h0400_0001;
    localparam logic [31:0] CF0W = 32'h4400_0001;
    localparam logic [31:0] CF1R = 32'h0500_0001;
    localparam logic [31:0] MSGN = 32'h3000_0000;
    localparam logic [31:0] MSGD = 32'h7000_0001;
    localparam logic [31:0] MSGL = 32'h7400_0001;
    localparam logic [31:0] CPLT = 32'h0A00_0000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 hdr_valid = 1'b0;
    logic [31:0]          hdr_dw0 = '0, hdr_dw1 = '0, hdr_dw2 = '0, hdr_dw3 = '0;
    logic [NB-1:0]        bar_en = '0, bar_is_io = '0, bar_is64 = '0;
    logic [NB-1:0][31:0]  bar_base = '0, bar_mask = '0;
    logic                 aer_enable = 1'b1;
    logic                 route_valid;
    logic [3:0]           route_onehot;
    logic [NB-1:0]        bar_hit;
    logic                 malformed, unsup_req, cpl_needed, drop, err_msg_req;

    always #5 clk = ~clk;

    rx_tlp_router #(.NUM_BAR(NB)) u_rx_tlp_router (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_valid    (hdr_valid),
        .hdr_dw0      (hdr_dw0),
        .hdr_dw1      (hdr_dw1),
        .hdr_dw2      (hdr_dw2),
        .hdr_dw3      (hdr_dw3),
        .bar_en       (bar_en),
        .bar_is_io    (bar_is_io),
        .bar_is64     (bar_is64),
        .bar_base     (bar_base),
        .bar_mask     (bar_mask),
        .aer_enable   (aer_enable),
        .route_valid  (route_valid),
        .route_onehot (route_onehot),
        .bar_hit      (bar_hit),
        .malformed    (malformed),
        .unsup_req    (unsup_req),
        .cpl_needed   (cpl_needed),
        .drop         (drop),
        .err_msg_req  (err_msg_req)
    );

    // Packed result: {route, bar_hit, malformed, unsup, cpl, drop, err}
    typedef logic [4+NB+5-1:0] res_t;

    res_t  exp_q[$];
    string tag_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    int    n_sent  = 0;
    int    n_seen  = 0;
    bit    done    = 1'b0;

    function automatic res_t pack(input logic [3:0] rt, input logic [NB-1:0] bh,
                                  input logic mal, input logic ur, input logic cpl,
                                  input logic err);
        return {rt, bh, mal, ur, cpl, rt[3], err};
    endfunction

    // Driver: present one header for one cycle and queue its expectation
    task automatic send(input logic [31:0] d0, input logic [31:0] d1,
                        input logic [31:0] d2, input logic [31:0] d3,
                        input logic [3:0] rt, input logic [NB-1:0] bh,
                        input logic mal, input logic ur, input logic cpl,
                        input logic err, input string tag);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_dw0 = d0; hdr_dw1 = d1; hdr_dw2 = d2; hdr_dw3 = d3;
        exp_q.push_back(pack(rt, bh, mal, ur, cpl, err));
        tag_q.push_back(tag);
        n_sent++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hdr_valid = 1'b0;
        end
    endtask

    // Monitor: compare every produced result against the queue head
    always @(negedge clk) begin
        if (rst_n && !done && route_valid) begin
            res_t  act;
            res_t  exp;
            string tag;
            act = {route_onehot, bar_hit, malformed, unsup_req, cpl_needed, drop, err_msg_req};
            n_seen++;
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected result act=%h exp=none", act);
            end else begin
                exp = exp_q.pop_front();
                tag = tag_q.pop_front();
                if (act !== exp) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", tag, act, exp);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        // Windows: 0 mem32 64KB @8000_0000, 1 I/O 256B @1000,
        // 2/3 mem64 256MB @1_0000_0000, 4/5 disabled
        bar_en       = 6'b000111;
        bar_is_io    = 6'b000010;
        bar_is64     = 6'b000100;
        bar_base[0]  = 32'h8000_0000; bar_mask[0] = 32'hFFFF_0000;
        bar_base[1]  = 32'h0000_1000; bar_mask[1] = 32'hFFFF_FF00;
        bar_base[2]  = 32'h0000_0000; bar_mask[2] = 32'hF000_0000;
        bar_base[3]  = 32'h0000_0001; bar_mask[3] = 32'hFFFF_FFFF;
        bar_base[4]  = 32'h8000_0000; bar_mask[4] = 32'hFF00_0000;
        bar_base[5]  = 32'h0000_0000; bar_mask[5] = 32'h0000_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        n_tests++;
        if (route_valid !== 1'b0 || route_onehot !== 4'b0 || drop !== 1'b0 ||
            malformed !== 1'b0 || err_msg_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset state act=%b%b exp=00000", route_valid, route_onehot);
        end

        // R1 memory hits, back to back
        send(MRD3, 0, 32'h8000_1234, 0, APP, 6'b000001, 0, 0, 0, 0, "R1 mrd3 hit w0");
        send(MWR3, 0, 32'h8000_FFF0, 0, APP, 6'b000001, 0, 0, 0, 0, "R1 mwr3 hit w0");
        // R3 64-bit pair
        send(MRD4, 0, 32'h0000_0001, 32'h0000_0040, APP, 6'b000100, 0, 0, 0, 0, "R3 mrd4 hit pair");
        send(MWR4, 0, 32'h0000_0001, 32'h1000_0000, DISC, 0, 0, 1, 0, 0, "R3 mwr4 past pair end");
        send(MRD4, 0, 32'h0000_0002, 32'h0000_0040, DISC, 0, 0, 1, 1, 0, "R3 mrd4 upper miss");
        idle(2);
        // R9 R10 malformed
        send(MRD4, 0, 32'h0000_0000, 32'h8000_0000, DISC, 0, 1, 0, 0, 1, "R10 malformed aer on");
        @(negedge clk); hdr_valid = 1'b0; aer_enable = 1'b0;
        send(MWR4, 0, 32'h0000_0000, 32'h0000_0010, DISC, 0, 1, 0, 0, 0, "R9 malformed aer off");
        idle(1);
        aer_enable = 1'b1;
        // R2 I/O vs memory windows
        send(IORD, 0, 32'h0000_1004, 0, APP, 6'b000010, 0, 0, 0, 0, "R2 io rd hit w1");
        send(IOWR, 0, 32'h0000_10FC, 0, APP, 6'b000010, 0, 0, 0, 0, "R2 io wr hit w1");
        send(IORD, 0, 32'h8000_0000, 0, DISC, 0, 0, 1, 1, 0, "R2 io to mem window");
        send(MRD3, 0, 32'h0000_1004, 0, DISC, 0, 0, 1, 1, 0, "R2 mem to io window");
        // R7 R8 no-hit memory
        send(MRD3, 0, 32'h0000_2000, 0, DISC, 0, 0, 1, 1, 0, "R8 mrd miss needs cpl");
        send(MWR3, 0, 32'h0000_2000, 0, DISC, 0, 0, 1, 0, 0, "R8 mwr miss posted");
        idle(1);
        // R5 configuration
        send(CF0R, 0, 32'h0000_0010, 0, CFG, 0, 0, 0, 0, 0, "R5 cfg0 rd");
        send(CF0W, 0, 32'h0000_0010, 0, CFG, 0, 0, 0, 0, 0, "R5 cfg0 wr");
        send(CF1R, 0, 32'h0100_0010, 0, DISC, 0, 0, 1, 1, 0, "R7 cfg1 unsupported");
        // R4 vendor messages
        send(MSGN, 32'h0000_007E, 0, 0, APP, 0, 0, 0, 0, 0, "R4 vendor msg 7E");
        send(MSGD, 32'h0000_007F, 0, 0, APP, 0, 0, 0, 0, 0, "R4 vendor msgd 7F");
        // R6 internal messages
        send(MSGN, 32'h0000_0018, 0, 0, MSG, 0, 0, 0, 0, 0, "R6 pme");
        send(MSGN, 32'h0000_0019, 0, 0, MSG, 0, 0, 0, 0, 0, "R6 pme turn off");
        send(MSGL, 32'h0000_0050, 0, 0, MSG, 0, 0, 0, 0, 0, "R6 slot power");
        // R7 other messages and types
        send(MSGN, 32'h0000_0020, 0, 0, DISC, 0, 0, 1, 0, 0, "R7 unknown msg code");
        send(CPLT, 0, 0, 0, DISC, 0, 0, 1, 0, 0, "R7 other type");
        idle(2);
        // R1 priority and enable
        bar_en = 6'b010111;
        send(MRD3, 0, 32'h8000_1234, 0, APP, 6'b000001, 0, 0, 0, 0, "R1 overlap lowest wins");
        send(MRD3, 0, 32'h80FF_0000, 0, APP, 6'b010000, 0, 0, 0, 0, "R1 hit w4 only");
        idle(1);
        bar_en = 6'b010110;
        send(MRD3, 0, 32'h8000_1234, 0, APP, 6'b010000, 0, 0, 0, 0, "R1 w0 disabled");
        idle(1);
        bar_en = 6'b000110;
        send(MRD3, 0, 32'h8000_1234, 0, DISC, 0, 0, 1, 1, 0, "R1 all mem32 disabled");
        idle(4);

        // R11 every header produced exactly one result
        n_tests++;
        if (exp_q.size() != 0 || n_seen != n_sent) begin
            n_fail++;
            $display("FAIL R11 result count act=%0d exp=%0d", n_seen, n_sent);
        end
        finish_run();
    end

endmodule